// File: doc/BRIEF.md
# Pipelined Multi-Hit TDC Readout Buffer

This block is the digital back end of a dead-time-free time-to-digital converter with 24 hit inputs. A free-running coarse counter advances once per clock. Each channel supplies its own 5-bit fine phase code. The block stamps the rising edge of every hit with a 17-bit time word: the 12 coarse bits sit above the 5 fine bits. Every stamp goes into a 256-entry circular buffer that all channels share. Entries are kept in arrival order.

Acquisition never pauses. While an event is being read out, new hits keep entering the buffer. When a trigger arrives, the block looks back from the trigger time over a programmable window and selects every stored hit inside it. It streams a header word, then one word per selected hit tagged with its channel, then a trailer word with the hit count. The output uses a valid/ready handshake. While no event is being read, hits older than the window are retired from the tail of the buffer to free space. When the buffer is full, new hits are dropped rather than overwriting stored data. Each drop is counted, and the next trailer is flagged.

Top module: `tdc_readout_buffer`

## Requirements
- R1: The coarse counter holds 0 after reset and then counts clock edges modulo 4096. A rising edge on channel c is sampled at a clock edge where the counter reads n and that channel's fine code is f. That hit gets the time n*32+f (17 bits).
- R2: Each channel holds one pending stamp. The buffer takes one stamp per clock, always choosing the lowest-numbered pending channel. Hits leave the buffer in the order they were written.
- R3: A trigger is sampled when the counter reads m, which gives a trigger time of m*32. The event then reports every stored hit at time t for which (m*32 - t) mod 2^17 <= window. The window must stay below 2^16.
- R4: Every output word carries its type in bits [31:30]. A header is 2'b10 and holds the event number in [15:0]. Event numbers start at 0 after reset and go up by one for each event served. A hit word is 2'b00 and holds the channel in [21:17] and the time in [16:0]. A trailer is 2'b11 and holds the overflow flag in [29] and the hit count in [8:0].
- R5: The buffer holds at most 256 entries, and its fill level never exceeds that.
- R6: A hit that finds the buffer full is dropped without touching stored entries. Each drop adds one to an 8-bit counter on `ovf_count_o`. The counter sticks at 255 instead of wrapping.
- R7: After any drop, the next trailer has its overflow flag set. The flag clears once that trailer is accepted.
- R8: While no event is being read, one entry per clock leaves the buffer tail if its age against the current time exceeds `window_i`.
- R9: An output word stays stable while `out_valid_o` is high and `out_ready_i` is low.
- R10: A trigger that arrives while an event is being read out is ignored. It produces no event and does not advance the event number.
- R11: Several hits on the same channel before one trigger are each reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_i | input | 24 | Hit levels, one bit per channel, synchronous to clk |
| fine_i | input | 120 | Fine phase code per channel, 5 bits each, channel c at [5c+4:5c] |
| trig_i | input | 1 | Trigger strobe |
| window_i | input | 17 | Look-back window in time LSBs |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 32 | Header, hit or trailer word |
| ovf_count_o | output | 8 | Saturating count of dropped hits |

## Verification
The assertions check four things on every cycle: the fill level stays within 256 and rises by at most one per clock, a stalled output word is held, the drop counter never goes backwards, and a write into a full buffer shows up as a drop. The bench scenarios cover the rest. They sweep the window against many hit ages and fine codes, including runs that cross the coarse wrap. They also check the order of hits stamped in the same cycle, fill the buffer past capacity to observe the drop count and the trailer flag, and show that retiring old entries empties the buffer. A final scenario confirms that a trigger arriving during readout leaves neither an event nor a gap in the event numbers.

// File: rtl/tdc_pkg.sv
// Shared constants and types of the TDC readout buffer.
// Assumes a 12-bit coarse counter and a 5-bit fine code per hit.
package tdc_pkg;
    localparam int COARSE_W = 12;
    localparam int FINE_W   = 5;
    localparam int TIME_W   = COARSE_W + FINE_W;
    localparam int CH_W     = 5;
    localparam int WORD_W   = 32;

    typedef struct packed {
        logic [CH_W-1:0]   ch;
        logic [TIME_W-1:0] t;
    } hit_rec_t;

    typedef enum logic [1:0] {
        WT_HIT = 2'b00,
        WT_HDR = 2'b10,
        WT_TRL = 2'b11
    } word_type_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_HDR,
        RD_SCAN,
        RD_TRL
    } rd_state_e;

    // Age of an earlier time seen from a later one, modulo the time range.
    function automatic logic [TIME_W-1:0] time_age(input logic [TIME_W-1:0] later,
                                                   input logic [TIME_W-1:0] earlier);
        return later - earlier;
    endfunction
endpackage

// File: rtl/tdc_coarse_timer.sv
// Free-running coarse counter, one step per clock, wrapping at 2^W.
// Assumes nothing; holds zero during reset.
module tdc_coarse_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count_o
);
    // Advance the counter every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) count_o <= '0;
        else        count_o <= count_o + 1'b1;
    end
endmodule

// File: rtl/tdc_hit_capture.sv
// Edge detection and time stamping for every channel, with one pending stamp
// per channel and a fixed-priority pick (lowest channel first) each clock.
// Assumes hit inputs are already synchronous. The pick is always consumed
// downstream (written or dropped). A new edge on a channel whose stamp is
// still waiting is reported as a drop.
module tdc_hit_capture
    import tdc_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int DROP_W = $clog2(NUM_CH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        hit_i,
    input  logic [NUM_CH*FINE_W-1:0] fine_i,
    input  logic [COARSE_W-1:0]      coarse_i,
    output logic                     req_o,
    output hit_rec_t                 rec_o,
    output logic [DROP_W-1:0]        drops_o
);
    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] grant;
    logic [NUM_CH-1:0] collide;
    logic [TIME_W-1:0] pend_t [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic              hit_q;
        logic              pv;
        logic [TIME_W-1:0] pt;
        logic              rise;

        assign rise       = hit_i[c] & ~hit_q;
        assign pend[c]    = pv;
        assign pend_t[c]  = pt;
        assign collide[c] = rise & pv & ~grant[c];

        // Track the input level and hold the newest stamp until it is picked.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hit_q <= 1'b0;
                pv    <= 1'b0;
                pt    <= '0;
            end else begin
                hit_q <= hit_i[c];
                if (rise) begin
                    pv <= 1'b1;
                    pt <= {coarse_i, fine_i[c*FINE_W +: FINE_W]};
                end else if (grant[c]) begin
                    pv <= 1'b0;
                end
            end
        end
    end

    // Pick the lowest pending channel.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        rec_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (pend[c] && !found) begin
                found    = 1'b1;
                grant[c] = 1'b1;
                rec_o.ch = CH_W'(c);
                rec_o.t  = pend_t[c];
            end
        end
    end

    // Count stamps lost to a second edge on a waiting channel.
    always_comb begin
        drops_o = '0;
        for (int c = 0; c < NUM_CH; c++) drops_o = drops_o + DROP_W'(collide[c]);
    end

    assign req_o = |pend;
endmodule

// File: rtl/tdc_hit_ring.sv
// Circular hit store shared by all channels. It writes one record per clock
// at the head, retires aged records from the tail, drops writes when full and
// counts every drop in a saturating counter.
// Assumes the reader freezes retirement while it scans, so scanned entries
// stay in place.
module tdc_hit_ring
    import tdc_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int OVF_W  = 8,
    parameter int DROP_W = 5,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  hit_rec_t          wr_rec_i,
    input  logic [DROP_W-1:0] ext_drops_i,
    input  logic [TIME_W-1:0] now_i,
    input  logic [TIME_W-1:0] window_i,
    input  logic              purge_en_i,
    input  logic [PTR_W-1:0]  rd_addr_i,
    output hit_rec_t          rd_rec_o,
    output logic [PTR_W:0]    head_o,
    output logic [PTR_W:0]    tail_o,
    output logic [PTR_W:0]    level_o,
    output logic [OVF_W-1:0]  ovf_count_o,
    output logic              drop_evt_o
);
    localparam logic [PTR_W:0] FULL_LVL = (PTR_W+1)'(DEPTH);
    localparam logic [OVF_W-1:0] OVF_MAX = {OVF_W{1'b1}};

    hit_rec_t          mem [DEPTH];
    logic              full;
    logic              do_write;
    logic              do_purge;
    logic [DROP_W:0]   drops_all;
    logic [OVF_W:0]    ovf_sum;

    assign level_o   = head_o - tail_o;
    assign full      = (level_o == FULL_LVL);
    assign do_write  = wr_en_i && !full;
    assign do_purge  = purge_en_i && (level_o != '0) &&
                       (time_age(now_i, mem[tail_o[PTR_W-1:0]].t) > window_i);
    assign drops_all = {1'b0, ext_drops_i} + {{DROP_W{1'b0}}, (wr_en_i & full)};
    assign ovf_sum   = {1'b0, ovf_count_o} + (OVF_W+1)'(drops_all);
    assign drop_evt_o = (drops_all != '0);
    assign rd_rec_o  = mem[rd_addr_i];

    // Store an accepted record at the head.
    always_ff @(posedge clk) begin
        if (do_write) mem[head_o[PTR_W-1:0]] <= wr_rec_i;
    end

    // Move head on writes and tail on retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_o <= '0;
            tail_o <= '0;
        end else begin
            if (do_write) head_o <= head_o + 1'b1;
            if (do_purge) tail_o <= tail_o + 1'b1;
        end
    end

    // Saturating count of dropped hits.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ovf_count_o <= '0;
        else if (ovf_sum > {1'b0, OVF_MAX}) ovf_count_o <= OVF_MAX;
        else                                ovf_count_o <= ovf_sum[OVF_W-1:0];
    end
endmodule

// File: rtl/tdc_event_reader.sv
// Per-trigger readout. It snapshots the buffer bounds and the window, streams
// a header, the hits inside the window and a trailer over valid/ready, and
// keeps the sticky overflow flag. Triggers are ignored while busy.
// Assumes the buffer entries between the snapshot tail and head stay valid
// for the whole scan.
module tdc_event_reader
    import tdc_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int EVT_W = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [TIME_W-1:0] now_i,
    input  logic [TIME_W-1:0] window_i,
    input  logic [PTR_W:0]    head_i,
    input  logic [PTR_W:0]    tail_i,
    output logic [PTR_W-1:0]  rd_addr_o,
    input  hit_rec_t          rd_rec_i,
    input  logic              drop_evt_i,
    input  logic              out_ready_i,
    output logic              out_valid_o,
    output logic [WORD_W-1:0] out_data_o,
    output logic              busy_o
);
    rd_state_e         st;
    logic [PTR_W:0]    rd_ptr;
    logic [PTR_W:0]    end_ptr;
    logic [TIME_W-1:0] trig_t;
    logic [TIME_W-1:0] win_q;
    logic [CNT_W-1:0]  hit_cnt;
    logic [EVT_W-1:0]  evt_num;
    logic              ovf_flag;
    logic              scan_done;
    logic              in_win;
    logic              take;
    logic              trl_acc;

    assign rd_addr_o = rd_ptr[PTR_W-1:0];
    assign scan_done = (rd_ptr == end_ptr);
    assign in_win    = (time_age(trig_t, rd_rec_i.t) <= win_q);
    assign take      = (st == RD_SCAN) && !scan_done && in_win;
    assign trl_acc   = (st == RD_TRL) && out_ready_i;
    assign busy_o    = (st != RD_IDLE);

    // Form the current output word.
    always_comb begin
        out_valid_o = 1'b0;
        out_data_o  = '0;
        case (st)
            RD_HDR: begin
                out_valid_o                  = 1'b1;
                out_data_o[31:30]            = WT_HDR;
                out_data_o[EVT_W-1:0]        = evt_num;
            end
            RD_SCAN: begin
                out_valid_o                  = take;
                out_data_o[31:30]            = WT_HIT;
                out_data_o[CH_W+TIME_W-1:0]  = {rd_rec_i.ch, rd_rec_i.t};
            end
            RD_TRL: begin
                out_valid_o                  = 1'b1;
                out_data_o[31:30]            = WT_TRL;
                out_data_o[29]               = ovf_flag;
                out_data_o[CNT_W-1:0]        = hit_cnt;
            end
            default: ;
        endcase
    end

    // Sequence the event: snapshot, header, scan, trailer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= RD_IDLE;
            rd_ptr  <= '0;
            end_ptr <= '0;
            trig_t  <= '0;
            win_q   <= '0;
            hit_cnt <= '0;
            evt_num <= '0;
        end else begin
            case (st)
                RD_IDLE: if (trig_i) begin
                    trig_t  <= now_i;
                    win_q   <= window_i;
                    rd_ptr  <= tail_i;
                    end_ptr <= head_i;
                    hit_cnt <= '0;
                    st      <= RD_HDR;
                end
                RD_HDR: if (out_ready_i) st <= RD_SCAN;
                RD_SCAN: begin
                    if (scan_done) begin
                        st <= RD_TRL;
                    end else if (!in_win) begin
                        rd_ptr <= rd_ptr + 1'b1;
                    end else if (out_ready_i) begin
                        rd_ptr  <= rd_ptr + 1'b1;
                        hit_cnt <= hit_cnt + 1'b1;
                    end
                end
                RD_TRL: if (out_ready_i) begin
                    evt_num <= evt_num + 1'b1;
                    st      <= RD_IDLE;
                end
                default: st <= RD_IDLE;
            endcase
        end
    end

    // Sticky overflow flag, reported and cleared by the next trailer.
    always_ff @(posedge clk) begin
        if (!rst_n)          ovf_flag <= 1'b0;
        else if (drop_evt_i) ovf_flag <= 1'b1;
        else if (trl_acc)    ovf_flag <= 1'b0;
    end
endmodule

// File: rtl/tdc_readout_buffer.sv
// Top of the TDC readout buffer. It joins the coarse timer, the per-channel
// capture, the shared ring and the event reader. Retirement of old hits is
// paused while an event is being read.
// Assumes window_i < 2^16 and at most 24 channels (5-bit channel tag).
module tdc_readout_buffer
    import tdc_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int DEPTH  = 256,
    parameter int OVF_W  = 8,
    parameter int EVT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        hit_i,
    input  logic [NUM_CH*FINE_W-1:0] fine_i,
    input  logic                     trig_i,
    input  logic [TIME_W-1:0]        window_i,
    output logic                     out_valid_o,
    input  logic                     out_ready_i,
    output logic [WORD_W-1:0]        out_data_o,
    output logic [OVF_W-1:0]         ovf_count_o
);
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int DROP_W = $clog2(NUM_CH + 1);

    logic [COARSE_W-1:0] coarse;
    logic [TIME_W-1:0]   now_t;
    logic                wr_req;
    hit_rec_t            wr_rec;
    logic [DROP_W-1:0]   cap_drops;
    logic [PTR_W-1:0]    rd_addr;
    hit_rec_t            rd_rec;
    logic [PTR_W:0]      head;
    logic [PTR_W:0]      tail;
    logic [PTR_W:0]      ring_level;
    logic                drop_evt;
    logic                busy;

    assign now_t = {coarse, {FINE_W{1'b0}}};

    tdc_coarse_timer #(.W(COARSE_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_o (coarse)
    );

    tdc_hit_capture #(.NUM_CH(NUM_CH), .DROP_W(DROP_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit_i),
        .fine_i   (fine_i),
        .coarse_i (coarse),
        .req_o    (wr_req),
        .rec_o    (wr_rec),
        .drops_o  (cap_drops)
    );

    tdc_hit_ring #(.DEPTH(DEPTH), .OVF_W(OVF_W), .DROP_W(DROP_W)) u_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_req),
        .wr_rec_i    (wr_rec),
        .ext_drops_i (cap_drops),
        .now_i       (now_t),
        .window_i    (window_i),
        .purge_en_i  (!busy),
        .rd_addr_i   (rd_addr),
        .rd_rec_o    (rd_rec),
        .head_o      (head),
        .tail_o      (tail),
        .level_o     (ring_level),
        .ovf_count_o (ovf_count_o),
        .drop_evt_o  (drop_evt)
    );

    tdc_event_reader #(.DEPTH(DEPTH), .EVT_W(EVT_W)) u_reader (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig_i),
        .now_i       (now_t),
        .window_i    (window_i),
        .head_i      (head),
        .tail_i      (tail),
        .rd_addr_o   (rd_addr),
        .rd_rec_i    (rd_rec),
        .drop_evt_i  (drop_evt),
        .out_ready_i (out_ready_i),
        .out_valid_o (out_valid_o),
        .out_data_o  (out_data_o),
        .busy_o      (busy)
    );
endmodule

// File: rtl/tdc_readout_buffer_checker.sv
// Cycle-level properties of the TDC readout buffer, bound to its top.
module tdc_readout_buffer_checker #(
    parameter int DEPTH = 256,
    parameter int OVF_W = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid_o,
    input logic             out_ready_i,
    input logic [31:0]      out_data_o,
    input logic [OVF_W-1:0] ovf_count_o,
    input logic [PTR_W:0]   ring_level,
    input logic             wr_req
);
    localparam logic [PTR_W:0]   FULL_LVL = (PTR_W+1)'(DEPTH);
    localparam logic [OVF_W-1:0] OVF_MAX  = {OVF_W{1'b1}};

    assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ring_level <= FULL_LVL);

    assert_one_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ring_level <= $past(ring_level) + 1'b1));

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    assert_ovf_mono_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ovf_count_o >= $past(ovf_count_o)));

    assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_level == FULL_LVL && wr_req && ovf_count_o != OVF_MAX)
        |=> (ovf_count_o != $past(ovf_count_o)));
endmodule

bind tdc_readout_buffer tdc_readout_buffer_checker #(.DEPTH(DEPTH), .OVF_W(OVF_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .ovf_count_o (ovf_count_o),
    .ring_level  (ring_level),
    .wr_req      (wr_req)
);

// File: tb/tdc_readout_buffer_bench.sv
// Self-checking bench: window sweep, simultaneous hits, overflow and flush.
module tdc_readout_buffer_bench;
    localparam int NUM_CH = 24;
    localparam int DEPTH  = 256;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NUM_CH-1:0]   hit_i = '0;
    logic [NUM_CH*5-1:0] fine_i = '0;
    logic                trig_i = 1'b0;
    logic [16:0]         window_i = '0;
    logic                out_valid_o;
    logic                out_ready_i = 1'b0;
    logic [31:0]         out_data_o;
    logic [7:0]          ovf_count_o;

    tdc_readout_buffer u_tdc_readout_buffer (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .fine_i(fine_i),
        .trig_i(trig_i), .window_i(window_i), .out_valid_o(out_valid_o),
        .out_ready_i(out_ready_i), .out_data_o(out_data_o), .ovf_count_o(ovf_count_o)
    );

    always #2 clk = ~clk;

    int          n_chk = 0;
    int          n_bad = 0;
    int unsigned cyc = 0;
    int unsigned wd = 0;
    logic [4:0]  mch [0:511];
    logic [16:0] mt  [0:511];
    int          mcnt = 0;
    int          mdrop = 0;
    bit          exp_flag = 0;
    int          exp_evt = 0;
    int          last_hits = 0;
    logic [31:0] got [0:299];

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd == 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic model_push(input int c, input logic [16:0] t);
        if (mcnt < DEPTH) begin
            mch[mcnt] = 5'(c); mt[mcnt] = t; mcnt++;
        end else begin
            mdrop++; exp_flag = 1;
        end
    endtask

    task automatic pulse(input int c, input int f);
        @(negedge clk);
        hit_i[c] = 1'b1;
        fine_i[c*5 +: 5] = 5'(f);
        model_push(c, {cyc[11:0], 5'(f)});
        @(negedge clk);
        hit_i[c] = 1'b0;
    endtask

    task automatic flush();
        window_i = '0;
        repeat (300) @(negedge clk);
        mcnt = 0;
    endtask

    task automatic run_event(input int pat, input bit inject);
        logic [16:0] tt;
        int ng = 0;
        int ne = 0;
        @(negedge clk);
        trig_i = 1'b1;
        tt = {cyc[11:0], 5'b0};
        for (int it = 0; it < 3000; it++) begin
            @(negedge clk);
            trig_i = inject && (it == 4);
            out_ready_i = (pat == 0) ? 1'b1 : (pat == 1) ? 1'(it % 2) : 1'(it % 3 == 2);
            if (out_valid_o && out_ready_i) begin
                got[ng] = out_data_o;
                ng++;
                if (out_data_o[31:30] == 2'b11 || ng == 300) break;
            end
        end
        @(negedge clk);
        out_ready_i = 1'b0;
        trig_i = 1'b0;
        chk(got[0][31:30] == 2'b10, "R4 header type", got[0][31:30], 2);
        chk(got[0][15:0] == 16'(exp_evt), "R4/R10 event number", got[0][15:0], exp_evt);
        for (int k = 0; k < mcnt; k++) begin
            logic [16:0] age;
            age = tt - mt[k];
            if (age <= window_i) begin
                if (1 + ne < ng)
                    chk(got[1+ne][31:30] == 2'b00 && got[1+ne][21:0] == {mch[k], mt[k]},
                        "R1/R2/R3 hit word", got[1+ne], {mch[k], mt[k]});
                ne++;
            end
        end
        chk(ng == ne + 2, "R3/R9/R11 words in event", ng, ne + 2);
        chk(got[ng-1][31:30] == 2'b11, "R4 trailer type", got[ng-1][31:30], 3);
        chk(got[ng-1][8:0] == 9'(ne), "R3/R11 trailer count", got[ng-1][8:0], ne);
        chk(got[ng-1][29] == exp_flag, "R7 trailer flag", got[ng-1][29], exp_flag);
        exp_flag = 0;
        exp_evt++;
        last_hits = ne;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(out_valid_o == 1'b0, "R4 idle after reset", out_valid_o, 0);
        chk(ovf_count_o == 8'd0, "R6 counter after reset", ovf_count_o, 0);
        rst_n = 1'b1;

        // Window sweep over ages, fine codes, repeats and ready patterns.
        for (int s = 0; s < 30; s++) begin
            int nh;
            flush();
            window_i = 17'((s * 37) % 480);
            nh = 1 + s % 6;
            for (int i = 0; i < nh; i++) begin
                int c;
                c = (s % 3 == 0) ? (s % 24) : ((s * 5 + i) % 24);
                pulse(c, (s * 7 + i * 11) % 32);
                repeat (i % 2) @(negedge clk);
            end
            repeat (3) @(negedge clk);
            run_event(s % 3, (s % 4 == 1) && (s % 3 == 2));
            if ((s % 4 == 1) && (s % 3 == 2)) begin
                int seen = 0;
                repeat (12) begin
                    @(negedge clk);
                    if (out_valid_o) seen++;
                end
                chk(seen == 0, "R10 no event from ignored trigger", seen, 0);
            end
        end

        // Simultaneous edges: lower channel written first.
        flush();
        window_i = 17'd2000;
        @(negedge clk);
        hit_i[17] = 1'b1; fine_i[17*5 +: 5] = 5'd31;
        hit_i[3]  = 1'b1; fine_i[3*5 +: 5]  = 5'd4;
        hit_i[9]  = 1'b1; fine_i[9*5 +: 5]  = 5'd20;
        model_push(3, {cyc[11:0], 5'd4});
        model_push(9, {cyc[11:0], 5'd20});
        model_push(17, {cyc[11:0], 5'd31});
        @(negedge clk);
        hit_i = '0;
        repeat (6) @(negedge clk);
        run_event(1, 0);
        chk(last_hits == 3, "R2 simultaneous hits kept", last_hits, 3);

        // Overflow: 300 hits into a 256-entry buffer.
        flush();
        window_i = 17'd30000;
        chk(ovf_count_o == 8'd0, "R6 no drops before fill", ovf_count_o, 0);
        mdrop = 0;
        for (int i = 0; i < 300; i++) pulse(7, i % 32);
        repeat (5) @(negedge clk);
        chk(ovf_count_o == 8'(mdrop), "R6 drop count", ovf_count_o, mdrop);
        run_event(0, 0);
        chk(last_hits == DEPTH, "R5 full buffer reported", last_hits, DEPTH);

        // Retirement empties the buffer; flag was cleared by previous trailer.
        flush();
        window_i = 17'd30000;
        run_event(2, 0);
        chk(last_hits == 0, "R8 aged hits retired", last_hits, 0);
        chk(ovf_count_o == 8'(mdrop), "R6 count held", ovf_count_o, mdrop);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule